// File: doc/BRIEF.md
# Calendar Time-Keeping Registers with Deferred Commit

This block counts wall-clock time in seconds, minutes, hours, day of month, month and a year offset. It steps forward once on each single-cycle `tick_1hz` strobe, which arrives from a slow one-hertz source as an enable in the block's clock domain. The clock part and the date part each appear as one packed 32-bit word. Software reads these words directly.

Software changes the time by writing a whole word. The write does not take effect at once. The block takes the value into a staging slot and raises a busy flag for that word. On the second tick after the write, the staged value replaces the running value and the flag drops. Until then the old value keeps counting, and any further write to the same word is dropped.

The month length comes from the month number and from a leap flag that software stores in the date word. The block never derives the flag from the year. A year offset has 64 values and wraps.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, `hms_o` reads 0x00000000, `ymd_o` reads 0x00000101 (day 1, month 1, year offset 0, leap flag 0) and `busy_o` reads 0.
- R2: Field positions. In `hms_o`, seconds sit at bits 5:0, minutes at 13:8 and hours at 20:16. In `ymd_o`, day sits at 4:0, month at 11:8, year offset at 21:16 and the leap flag at bit 22. All other bits read 0, including after a write that had those bits set.
- R3: A write to the clock word (`wr_hms`) sets `busy_o[1]` in the next cycle. At the second `tick_1hz` after the write, the staged value is loaded and `busy_o[1]` clears. Until then the previous time keeps advancing.
- R4: A write to the date word (`wr_ymd`) sets `busy_o[0]`. It commits and clears on the second tick after the write, in the same way as R3.
- R5: On a tick, seconds go up by one. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R6: A day carry wraps the day to 1 and advances the month after day 30 in months 4, 6, 9 and 11. In month 2 it does so after day 29 when the leap flag is 1, and after day 28 when it is 0. In every other month it does so after day 31.
- R7: Month wraps from 12 to 1 and increments the year offset. The year offset wraps from 63 to 0. Rollover never changes the leap flag.
- R8: A write to a word whose busy bit is already set is ignored. The value committed is the first one written.
- R9: On a commit tick, the committed word takes the staged value with no increment. A clock-word commit also suppresses the day carry that the old time would have produced. A date-word commit takes precedence over a day carry on the same tick.
- R10: `busy_o[2]` is reserved for an alarm-register busy indication and always reads 0.
- R11: In a cycle without `tick_1hz`, neither `hms_o` nor `ymd_o` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| wr_hms | input | 1 | Write strobe for the clock word |
| wr_ymd | input | 1 | Write strobe for the date word |
| wr_data | input | 32 | Data for either write strobe |
| hms_o | output | 32 | Packed hours, minutes and seconds |
| ymd_o | output | 32 | Packed leap flag, year offset, month and day |
| busy_o | output | 3 | Commit pending: bit 0 date word, bit 1 clock word, bit 2 reserved |

## Verification
Random tick density mixed with random writes tests whether the counting path and the deferred commit path interfere. Random writes are placed both near midnight and at arbitrary times. This shows whether a carry is lost, doubled or applied across a commit.

Directed month-end dates are written with the leap flag set and clear. These separate the four month lengths from one another, and show that the year wraps while the leap flag survives.

Back-to-back writes show whether the first staged value is kept. Writes timed so that their commit lands on a midnight tick show which source wins when the two compete.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YR_W   = 6;

    localparam int SEC_MAX = 59;
    localparam int MIN_MAX = 59;
    localparam int HR_MAX  = 23;
    localparam int MON_MAX = 12;

    typedef struct packed {
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] min;
        logic [SEC_W-1:0] sec;
    } hms_t;

    typedef struct packed {
        logic             leap;
        logic [YR_W-1:0]  yr;
        logic [MON_W-1:0] mon;
        logic [DAY_W-1:0] day;
    } ymd_t;

    typedef struct packed {
        hms_t hms;
        ymd_t ymd;
    } cal_t;

    // Last day of the month; February depends on the stored leap flag.
    function automatic logic [DAY_W-1:0] month_last_day(input logic [MON_W-1:0] mon,
                                                        input logic leap);
        logic [DAY_W-1:0] last;
        case (mon)
            4'd2:                      last = leap ? DAY_W'(29) : DAY_W'(28);
            4'd4, 4'd6, 4'd9, 4'd11:   last = DAY_W'(30);
            default:                   last = DAY_W'(31);
        endcase
        return last;
    endfunction

endpackage

// File: rtl/cal_time_adv.sv
module cal_time_adv
    import rtc_cal_pkg::*;
(
    input  hms_t cur,
    output hms_t nxt,
    output logic day_carry
);
    logic sec_wrap;
    logic min_wrap;
    logic hr_wrap;

    always_comb begin
        sec_wrap  = (cur.sec >= SEC_W'(SEC_MAX));
        min_wrap  = (cur.min >= MIN_W'(MIN_MAX));
        hr_wrap   = (cur.hr  >= HR_W'(HR_MAX));
        nxt       = cur;
        day_carry = 1'b0;
        if (!sec_wrap) begin
            nxt.sec = cur.sec + SEC_W'(1);
        end else begin
            nxt.sec = '0;
            if (!min_wrap) begin
                nxt.min = cur.min + MIN_W'(1);
            end else begin
                nxt.min = '0;
                if (!hr_wrap) begin
                    nxt.hr = cur.hr + HR_W'(1);
                end else begin
                    nxt.hr    = '0;
                    day_carry = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cal_date_adv.sv
module cal_date_adv
    import rtc_cal_pkg::*;
(
    input  ymd_t cur,
    output ymd_t nxt
);
    logic [DAY_W-1:0] last_day;

    always_comb begin
        last_day = month_last_day(cur.mon, cur.leap);
        nxt      = cur;
        if (cur.day < last_day) begin
            nxt.day = cur.day + DAY_W'(1);
        end else begin
            nxt.day = DAY_W'(1);
            if (cur.mon < MON_W'(MON_MAX)) begin
                nxt.mon = cur.mon + MON_W'(1);
            end else begin
                nxt.mon = MON_W'(1);
                nxt.yr  = cur.yr + YR_W'(1);
            end
        end
    end
endmodule

// File: rtl/cal_commit_slot.sv
module cal_commit_slot #(
    parameter int W            = 17,
    parameter int COMMIT_TICKS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic         busy,
    output logic         commit,
    output logic [W-1:0] staged
);
    localparam int CW = (COMMIT_TICKS < 2) ? 1 : $clog2(COMMIT_TICKS);
    localparam logic [CW-1:0] LAST = CW'(COMMIT_TICKS - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  data;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = st_q.busy && tick && (st_q.cnt == LAST);
        if (!st_q.busy) begin
            if (wr) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.data = wr_data;
            end
        end else if (tick) begin
            if (commit) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign staged = st_q.data;

    // R3: the busy flag only rises after a write strobe
    a_r3_rise_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |-> $past(wr));
    // R3: the busy flag only drops on a tick
    a_r3_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(tick));
    // R8: while pending, the staged value is held
    a_r8_staged_held: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(st_q.data));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int COMMIT_TICKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic        wr_hms,
    input  logic        wr_ymd,
    input  logic [31:0] wr_data,
    output logic [31:0] hms_o,
    output logic [31:0] ymd_o,
    output logic [2:0]  busy_o
);
    localparam int HMS_W = $bits(hms_t);
    localparam int YMD_W = $bits(ymd_t);

    cal_t st_d, st_q;

    hms_t wr_hms_val, hms_staged, hms_next;
    ymd_t wr_ymd_val, ymd_staged, ymd_next;
    logic hms_busy, hms_commit, ymd_busy, ymd_commit, day_carry;
    logic unused_wr_bits;

    assign wr_hms_val     = '{hr: wr_data[20:16], min: wr_data[13:8], sec: wr_data[5:0]};
    assign wr_ymd_val     = '{leap: wr_data[22], yr: wr_data[21:16],
                              mon: wr_data[11:8], day: wr_data[4:0]};
    assign unused_wr_bits = ^{wr_data[31:23], wr_data[15:14], wr_data[7:6]};

    cal_commit_slot #(.W(HMS_W), .COMMIT_TICKS(COMMIT_TICKS)) u_hms_slot (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr(wr_hms),
        .wr_data(wr_hms_val), .busy(hms_busy), .commit(hms_commit),
        .staged(hms_staged)
    );

    cal_commit_slot #(.W(YMD_W), .COMMIT_TICKS(COMMIT_TICKS)) u_ymd_slot (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .wr(wr_ymd),
        .wr_data(wr_ymd_val), .busy(ymd_busy), .commit(ymd_commit),
        .staged(ymd_staged)
    );

    cal_time_adv u_time_adv (.cur(st_q.hms), .nxt(hms_next), .day_carry(day_carry));
    cal_date_adv u_date_adv (.cur(st_q.ymd), .nxt(ymd_next));

    always_comb begin
        st_d = st_q;
        if (hms_commit) begin
            st_d.hms = hms_staged;
        end else if (tick_1hz) begin
            st_d.hms = hms_next;
        end
        if (ymd_commit) begin
            st_d.ymd = ymd_staged;
        end else if (tick_1hz && day_carry && !hms_commit) begin
            st_d.ymd = ymd_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hms <= '0;
            st_q.ymd <= '{leap: 1'b0, yr: '0, mon: MON_W'(1), day: DAY_W'(1)};
        end else begin
            st_q <= st_d;
        end
    end

    assign hms_o  = {11'b0, st_q.hms.hr, 2'b0, st_q.hms.min, 2'b0, st_q.hms.sec};
    assign ymd_o  = {9'b0, st_q.ymd.leap, st_q.ymd.yr, 4'b0, st_q.ymd.mon,
                     3'b0, st_q.ymd.day};
    assign busy_o = {1'b0, hms_busy, ymd_busy};

    // R11: no tick, no change to the clock word
    a_r11_hms_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1hz |=> $stable(hms_o));
    // R11: no tick, no change to the date word
    a_r11_ymd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1hz |=> $stable(ymd_o));
    // R5: a plain tick moves seconds up by exactly one
    a_r5_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !hms_commit && st_q.hms.sec < SEC_W'(SEC_MAX))
        |=> (st_q.hms.sec == $past(st_q.hms.sec) + SEC_W'(1)));
endmodule

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] HMS_MASK = 32'h001F_3F3F;
    localparam logic [31:0] YMD_MASK = 32'h007F_0F1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        wr_hms = 1'b0;
    logic        wr_ymd = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] hms_o, ymd_o;
    logic [2:0]  busy_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_hms, m_ymd, m_st_h, m_st_d;
    logic        m_bh, m_bd;
    int          m_ch, m_cd;

    rtc_calendar u_rtc_calendar (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_hms(wr_hms),
        .wr_ymd(wr_ymd), .wr_data(wr_data), .hms_o(hms_o), .ymd_o(ymd_o),
        .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int last_day(input int mon, input int leap);
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] inc_hms(input logic [31:0] w);
        int tot;
        tot = int'(w[20:16]) * 3600 + int'(w[13:8]) * 60 + int'(w[5:0]) + 1;
        tot = tot % 86400;
        return (32'(tot / 3600) << 16) | (32'((tot / 60) % 60) << 8) | 32'(tot % 60);
    endfunction

    function automatic logic [31:0] inc_ymd(input logic [31:0] w);
        int d, m, y, lp;
        d = int'(w[4:0]); m = int'(w[11:8]); y = int'(w[21:16]); lp = int'(w[22]);
        if (d < last_day(m, lp)) d = d + 1;
        else begin
            d = 1;
            if (m == 12) begin m = 1; y = (y + 1) % 64; end
            else m = m + 1;
        end
        return (32'(lp) << 22) | (32'(y) << 16) | (32'(m) << 8) | 32'(d);
    endfunction

    function automatic logic [31:0] rand_hms();
        if ($urandom % 2 == 0)
            return (32'd23 << 16) | (32'd59 << 8) | 32'(50 + $urandom % 10);
        return (32'($urandom % 24) << 16) | (32'($urandom % 60) << 8) | 32'($urandom % 60);
    endfunction

    function automatic logic [31:0] rand_ymd();
        int m, lp, d;
        m  = 1 + int'($urandom % 12);
        lp = int'($urandom % 2);
        d  = ($urandom % 2 == 0) ? last_day(m, lp) : 1 + int'($urandom % last_day(m, lp));
        return (32'($urandom) & 32'hFF80_F0E0) | (32'(lp) << 22) |
               (32'($urandom % 64) << 16) | (32'(m) << 8) | 32'(d);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step(input logic t, input logic wh, input logic wd, input logic [31:0] d);
        logic [31:0] n_hms, n_ymd;
        logic cm_h, cm_d, carry;
        @(negedge clk);
        tick_1hz = t; wr_hms = wh; wr_ymd = wd; wr_data = d;
        cm_h  = m_bh && t && (m_ch == 1);
        cm_d  = m_bd && t && (m_cd == 1);
        carry = t && !cm_h && (m_hms == 32'h0017_3B3B);
        n_hms = cm_h ? m_st_h : (t ? inc_hms(m_hms) : m_hms);
        n_ymd = cm_d ? m_st_d : (carry ? inc_ymd(m_ymd) : m_ymd);
        if (!m_bh && wh) begin m_bh = 1'b1; m_ch = 0; m_st_h = d & HMS_MASK; end
        else if (m_bh && t) begin if (cm_h) m_bh = 1'b0; else m_ch++; end
        if (!m_bd && wd) begin m_bd = 1'b1; m_cd = 0; m_st_d = d & YMD_MASK; end
        else if (m_bd && t) begin if (cm_d) m_bd = 1'b0; else m_cd++; end
        m_hms = n_hms; m_ymd = n_ymd;
        @(posedge clk); #1;
        chk("R5 clock word vs model", hms_o, m_hms);
        chk("R6 date word vs model", ymd_o, m_ymd);
        chk("R3 busy vs model", {29'b0, busy_o}, {29'b0, 1'b0, m_bh, m_bd});
    endtask

    task automatic put_hms(input logic [31:0] d);
        step(1'b0, 1'b1, 1'b0, d); step(1'b1, 1'b0, 1'b0, '0); step(1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic put_ymd(input logic [31:0] d);
        step(1'b0, 1'b0, 1'b1, d); step(1'b1, 1'b0, 1'b0, '0); step(1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic month_end(input logic [31:0] date, input logic [31:0] exp, input string tag);
        put_ymd(date);
        put_hms(32'h0017_3B3B);
        step(1'b1, 1'b0, 1'b0, '0);
        chk(tag, ymd_o, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_CA1E));
        m_hms = '0; m_ymd = 32'h0000_0101; m_bh = 0; m_bd = 0; m_ch = 0; m_cd = 0;
        m_st_h = '0; m_st_d = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R1 reset clock word", hms_o, 32'h0);
        chk("R1 reset date word", ymd_o, 32'h0000_0101);
        chk("R1 reset busy", {29'b0, busy_o}, 32'h0);

        // R3 deferred commit of the clock word, old time keeps counting
        step(1'b0, 1'b1, 1'b0, 32'h0017_3B3A);
        chk("R3 busy set after write", {29'b0, busy_o}, 32'h2);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R3 old time advances before commit", hms_o, 32'h1);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R9 commit loads without increment", hms_o, 32'h0017_3B3A);
        chk("R3 busy clear after second tick", {29'b0, busy_o}, 32'h0);

        // R4 / R9: date commit lands on the midnight tick and wins
        step(1'b0, 1'b0, 1'b1, 32'h007F_0C1F);
        chk("R4 date busy set", {29'b0, busy_o}, 32'h1);
        step(1'b1, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R9 date commit beats carry", ymd_o, 32'h007F_0C1F);
        chk("R5 hours wrap to zero", hms_o, 32'h0);

        // R7 year wrap with leap flag held
        put_hms(32'h0017_3B3B);
        chk("R9 clock commit suppresses carry", ymd_o, 32'h007F_0C1F);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R7 year wraps, leap kept", ymd_o, 32'h0040_0101);

        // R6 month lengths
        month_end(32'h004A_021C, 32'h004A_021D, "R6 Feb 28 leap");
        month_end(32'h004A_021D, 32'h004A_0301, "R6 Feb 29 leap");
        month_end(32'h000A_021C, 32'h000A_0301, "R6 Feb 28 no leap");
        month_end(32'h000A_041E, 32'h000A_0501, "R6 Apr 30");
        month_end(32'h000A_011F, 32'h000A_0201, "R6 Jan 31");
        month_end(32'h000A_0C1F, 32'h000B_0101, "R7 Dec 31 to next year");

        // R5 minute carry
        put_hms(32'h0000_3B3B);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R5 minute carry", hms_o, 32'h0001_0000);

        // R2 unused bits dropped
        put_hms(32'hFFE0_C0C0 | 32'h000C_1E2D);
        chk("R2 clock fields", hms_o, 32'h000C_1E2D);
        put_ymd(32'hFF80_F0E0 | 32'h0025_0710);
        chk("R2 date fields", ymd_o, 32'h0025_0710);

        // R8 second write while busy is ignored
        step(1'b0, 1'b1, 1'b0, 32'h0001_0203);
        step(1'b0, 1'b1, 1'b0, 32'h0005_0505);
        step(1'b0, 1'b0, 1'b1, 32'h0001_0101);
        chk("R10 reserved busy bit", {29'b0, busy_o}, 32'h3);
        step(1'b1, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, 1'b0, '0);
        chk("R8 first write kept", hms_o, 32'h0001_0203);

        // R11 no tick, no change
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, '0);
        chk("R11 clock held", hms_o, 32'h0001_0203);
        chk("R11 date held", ymd_o, 32'h0001_0101);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic t, wh, wd;
            logic [31:0] d;
            t  = ($urandom % 3 == 0);
            wh = ($urandom % 12 == 0);
            wd = !wh && ($urandom % 12 == 0);
            d  = wh ? (rand_hms() | (32'($urandom) & 32'hFFE0_C0C0)) : rand_ymd();
            step(t, wh, wd, d);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule